// File: doc/BRIEF.md
# Cipher Accelerator Status Flag Unit

This block holds the status and interrupt flags of a block-cipher engine. It follows the engine's data phase as it moves from loading input words, through a fixed-length computation, to unloading output words, and back to loading. A write to the data-in port outside the loading phase, or a read from the data-out port outside the unloading phase, is recorded as an access error. Such an error never alters the phase sequence.

A completion flag is raised when the engine reports that a computation has finished. One interrupt line combines the three flags with two enables. Software clears the flags through write-one strobes and reads them as a 32-bit status word. The cipher datapath is stood in for by a done pulse that follows a fixed latency.

Error detection is switched off while the key-derivation mode is selected. The completion flag is only updated while output DMA is disabled.

Top module: `cipher_status_unit`

## Requirements
- R1: After synchronous reset, `status_o` is 0, `irq_o` is 0 and `phase_o` is 0 (loading).
- R2: Bits 31:3 of `status_o` always read 0. Bit 2 is the write-error flag, bit 1 is the read-error flag and bit 0 is the completion flag.
- R3: `phase_o` encodes loading as 0, computing as 1 and unloading as 2. The WORDS-th `din_wr` in loading moves the phase to computing. Computing lasts LATENCY cycles and then moves to unloading. The WORDS-th `dout_rd` in unloading returns the phase to loading.
- R4: A `din_wr` while `phase_o` is 1 or 2 sets bit 2 of `status_o` on the next cycle.
- R5: A `dout_rd` while `phase_o` is 0 or 1 sets bit 1 of `status_o` on the next cycle.
- R6: A one-cycle `err_clr` clears bits 2 and 1 together on the next cycle.
- R7: While `key_deriv` is 1, no access sets bit 2 or bit 1.
- R8: An out-of-phase access does not advance the phase. A write during computing or unloading, and a read during loading or computing, leave the phase sequence unchanged.
- R9: When `dma_out_en` is 0, bit 0 is set one cycle after the phase enters unloading. A one-cycle `ccf_clr` clears it.
- R10: While `dma_out_en` is 1, a finished computation does not set bit 0, and bit 0 keeps its value unless `ccf_clr` is given.
- R11: If a flag's set event and its clear strobe occur in the same cycle, the flag is set.
- R12: `irq_o` is registered. One cycle after the flags change, it equals (bit 0 AND `ccf_ie`) OR ((bit 2 OR bit 1) AND `err_ie`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din_wr | input | 1 | Data-in register write strobe |
| dout_rd | input | 1 | Data-out register read strobe |
| key_deriv | input | 1 | Key-derivation mode selected |
| dma_out_en | input | 1 | Output DMA enabled |
| err_clr | input | 1 | Write-one strobe clearing both error flags |
| ccf_clr | input | 1 | Write-one strobe clearing the completion flag |
| err_ie | input | 1 | Error interrupt enable |
| ccf_ie | input | 1 | Completion interrupt enable |
| status_o | output | 32 | Status word |
| irq_o | output | 1 | Combined interrupt request |
| phase_o | output | 2 | Current engine phase |

## Verification
Each kind of access (write or read) is tried in each of the three phases, with key derivation both off and on. The expected error bits come from a simple phase-membership rule, so this sweep separates a wrong phase decode from a missing key-derivation gate. Interrupt enables are swept over all four combinations against each single flag source. This exposes swapped enables and a missing register stage. Targeted sequences put a set and a clear in the same cycle, stream writes through the computing phase to show that stray accesses do not stretch it, and run computations with DMA output enabled and disabled.

// File: rtl/csu_pkg.sv
package csu_pkg;
  typedef enum logic [1:0] {
    PH_INPUT   = 2'd0,
    PH_COMPUTE = 2'd1,
    PH_OUTPUT  = 2'd2
  } phase_e;

  localparam int unsigned NFLAG   = 3;
  localparam int unsigned FL_CCF  = 0;
  localparam int unsigned FL_RDE  = 1;
  localparam int unsigned FL_WRE  = 2;
endpackage

// File: rtl/csu_phase_ctrl.sv
module csu_phase_ctrl
  import csu_pkg::*;
#(
  parameter int unsigned WORDS   = 4,
  parameter int unsigned LATENCY = 10
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   din_wr,
  input  logic   dout_rd,
  output phase_e phase_o,
  output logic   done_o
);
  localparam int unsigned WCW = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int unsigned LCW = (LATENCY > 1) ? $clog2(LATENCY) : 1;
  localparam logic [WCW-1:0] WLAST = WCW'(WORDS - 1);
  localparam logic [LCW-1:0] LLAST = LCW'(LATENCY - 1);

  phase_e         phase_q;
  logic [WCW-1:0] word_q;
  logic [LCW-1:0] lat_q;
  logic           done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_INPUT;
      word_q  <= '0;
      lat_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        PH_INPUT: begin
          if (din_wr) begin
            if (word_q == WLAST) begin
              word_q  <= '0;
              lat_q   <= '0;
              phase_q <= PH_COMPUTE;
            end else begin
              word_q <= word_q + 1'b1;
            end
          end
        end
        PH_COMPUTE: begin
          if (lat_q == LLAST) begin
            lat_q   <= '0;
            done_q  <= 1'b1;
            phase_q <= PH_OUTPUT;
          end else begin
            lat_q <= lat_q + 1'b1;
          end
        end
        PH_OUTPUT: begin
          if (dout_rd) begin
            if (word_q == WLAST) begin
              word_q  <= '0;
              phase_q <= PH_INPUT;
            end else begin
              word_q <= word_q + 1'b1;
            end
          end
        end
        default: phase_q <= PH_INPUT;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign done_o  = done_q;

  // R3: computation exits to unloading exactly at the latency limit
  p_comp_exit_r3: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_COMPUTE && lat_q == LLAST) |=> (phase_q == PH_OUTPUT && done_q));
  // R3: done only accompanies the unloading phase
  p_done_phase_r3: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (phase_q == PH_OUTPUT));
  // R8: stray accesses never advance loading or unloading
  p_in_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_INPUT && !din_wr) |=> (phase_q == PH_INPUT));
  p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_OUTPUT && !dout_rd) |=> (phase_q == PH_OUTPUT));
endmodule

// File: rtl/csu_sticky_flag.sv
module csu_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst)        flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R11: a set in the same cycle as a clear leaves the flag high
  p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_q);
  // R6 / R9: a clear without a set drops the flag
  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !flag_q);
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !set_i) |=> $stable(flag_q));
endmodule

// File: rtl/csu_flag_bank.sv
module csu_flag_bank
  import csu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  phase_e           phase_i,
  input  logic             done_i,
  input  logic             din_wr,
  input  logic             dout_rd,
  input  logic             key_deriv,
  input  logic             dma_out_en,
  input  logic             err_clr,
  input  logic             ccf_clr,
  output logic [NFLAG-1:0] flags_o
);
  logic [NFLAG-1:0] set_v;
  logic [NFLAG-1:0] clr_v;

  always_comb begin
    set_v         = '0;
    clr_v         = '0;
    set_v[FL_WRE] = din_wr  && (phase_i != PH_INPUT)  && !key_deriv;
    set_v[FL_RDE] = dout_rd && (phase_i != PH_OUTPUT) && !key_deriv;
    set_v[FL_CCF] = done_i && !dma_out_en;
    clr_v[FL_WRE] = err_clr;
    clr_v[FL_RDE] = err_clr;
    clr_v[FL_CCF] = ccf_clr;
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    csu_sticky_flag u_flag (
      .clk    (clk),
      .rst    (rst),
      .set_i  (set_v[g]),
      .clr_i  (clr_v[g]),
      .flag_o (flags_o[g])
    );
  end

  // R4: write outside loading raises the write-error flag
  p_wr_detect_r4: assert property (@(posedge clk) disable iff (rst)
    (din_wr && phase_i != PH_INPUT && !key_deriv) |=> flags_o[FL_WRE]);
  // R5: read outside unloading raises the read-error flag
  p_rd_detect_r5: assert property (@(posedge clk) disable iff (rst)
    (dout_rd && phase_i != PH_OUTPUT && !key_deriv) |=> flags_o[FL_RDE]);
  // R7: key derivation keeps clear error flags clear
  p_kd_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (key_deriv && !flags_o[FL_WRE] && !flags_o[FL_RDE])
      |=> (!flags_o[FL_WRE] && !flags_o[FL_RDE]));
  // R10: with output DMA on, completion flag only moves on a clear
  p_dma_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (dma_out_en && !ccf_clr) |=> $stable(flags_o[FL_CCF]));
endmodule

// File: rtl/csu_irq_gen.sv
module csu_irq_gen
  import csu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] flags_i,
  input  logic             err_ie,
  input  logic             ccf_ie,
  output logic             irq_o
);
  logic ccf_req;
  logic err_req;
  logic irq_q;

  assign ccf_req = flags_i[FL_CCF] && ccf_ie;
  assign err_req = (flags_i[FL_WRE] || flags_i[FL_RDE]) && err_ie;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= ccf_req || err_req;
  end

  assign irq_o = irq_q;

  // R12: an enabled completion flag raises the line a cycle later
  p_irq_ccf_r12: assert property (@(posedge clk) disable iff (rst)
    (flags_i[FL_CCF] && ccf_ie) |=> irq_o);
  // R12: an enabled error flag raises the line a cycle later
  p_irq_err_r12: assert property (@(posedge clk) disable iff (rst)
    ((flags_i[FL_WRE] || flags_i[FL_RDE]) && err_ie) |=> irq_o);
  // R12: nothing enabled and pending keeps the line low
  p_irq_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    (!(flags_i[FL_CCF] && ccf_ie) && !((flags_i[FL_WRE] || flags_i[FL_RDE]) && err_ie))
      |=> !irq_o);
endmodule

// File: rtl/cipher_status_unit.sv
module cipher_status_unit
  import csu_pkg::*;
#(
  parameter int unsigned WORDS   = 4,
  parameter int unsigned LATENCY = 10,
  parameter int unsigned STAT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din_wr,
  input  logic              dout_rd,
  input  logic              key_deriv,
  input  logic              dma_out_en,
  input  logic              err_clr,
  input  logic              ccf_clr,
  input  logic              err_ie,
  input  logic              ccf_ie,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_o,
  output logic [1:0]        phase_o
);
  phase_e           phase;
  logic             done;
  logic [NFLAG-1:0] flags;

  csu_phase_ctrl #(
    .WORDS   (WORDS),
    .LATENCY (LATENCY)
  ) u_phase (
    .clk     (clk),
    .rst     (rst),
    .din_wr  (din_wr),
    .dout_rd (dout_rd),
    .phase_o (phase),
    .done_o  (done)
  );

  csu_flag_bank u_flags (
    .clk        (clk),
    .rst        (rst),
    .phase_i    (phase),
    .done_i     (done),
    .din_wr     (din_wr),
    .dout_rd    (dout_rd),
    .key_deriv  (key_deriv),
    .dma_out_en (dma_out_en),
    .err_clr    (err_clr),
    .ccf_clr    (ccf_clr),
    .flags_o    (flags)
  );

  csu_irq_gen u_irq (
    .clk     (clk),
    .rst     (rst),
    .flags_i (flags),
    .err_ie  (err_ie),
    .ccf_ie  (ccf_ie),
    .irq_o   (irq_o)
  );

  assign status_o = STAT_W'(flags);
  assign phase_o  = phase;

  // R1: one cycle out of reset everything reads idle
  p_reset_idle_r1: assert property (@(posedge clk)
    $fell(rst) |-> (status_o == '0 && !irq_o && phase_o == 2'd0));
endmodule

// File: tb/cipher_status_unit_tb_top.sv
`timescale 1ns/1ps
module cipher_status_unit_tb_top;
  localparam int WORDS = 4;
  localparam int LAT   = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din_wr = 0, dout_rd = 0, key_deriv = 0, dma_out_en = 0;
  logic err_clr = 0, ccf_clr = 0, err_ie = 0, ccf_ie = 0;
  logic [31:0] status;
  logic irq;
  logic [1:0] phase;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cipher_status_unit #(.WORDS(WORDS), .LATENCY(LAT), .STAT_W(32)) dut_i (
    .clk(clk), .rst(rst), .din_wr(din_wr), .dout_rd(dout_rd),
    .key_deriv(key_deriv), .dma_out_en(dma_out_en), .err_clr(err_clr),
    .ccf_clr(ccf_clr), .err_ie(err_ie), .ccf_ie(ccf_ie),
    .status_o(status), .irq_o(irq), .phase_o(phase)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1; din_wr = 0; dout_rd = 0; key_deriv = 0; dma_out_en = 0;
    err_clr = 0; ccf_clr = 0; err_ie = 0; ccf_ie = 0;
    tick(); tick();
    rst = 0;
  endtask

  task automatic wr_word();
    din_wr = 1; tick(); din_wr = 0;
  endtask

  task automatic rd_word();
    dout_rd = 1; tick(); dout_rd = 0;
  endtask

  task automatic go_compute();
    for (int i = 0; i < WORDS; i++) wr_word();
  endtask

  initial begin
    #(10 * 100000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] ew, er;
    logic        exp_irq;

    // R1 reset state
    do_reset();
    tick();
    check("R1 status", status, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 phase", {30'b0, phase}, 32'h0);

    // R3 / R9 full sequence
    for (int i = 0; i < WORDS - 1; i++) wr_word();
    check("R3 still loading", {30'b0, phase}, 32'd0);
    wr_word();
    check("R3 computing", {30'b0, phase}, 32'd1);
    repeat (LAT - 1) tick();
    check("R3 latency not done", {30'b0, phase}, 32'd1);
    tick();
    check("R3 unloading", {30'b0, phase}, 32'd2);
    check("R9 ccf not yet", status, 32'h0);
    tick();
    check("R9 ccf set", status, 32'h1);
    check("R12 irq disabled", {31'b0, irq}, 32'h0);
    for (int i = 0; i < WORDS - 1; i++) rd_word();
    check("R3 still unloading", {30'b0, phase}, 32'd2);
    rd_word();
    check("R3 back to loading", {30'b0, phase}, 32'd0);
    check("R9 ccf holds", status, 32'h1);
    ccf_clr = 1; tick(); ccf_clr = 0;
    check("R9 ccf cleared", status, 32'h0);

    // R4 R5 R7 R6 R2 sweep: phase x key-derivation x access kind
    for (int ph = 0; ph < 3; ph++) begin
      for (int kd = 0; kd < 2; kd++) begin
        for (int acc = 0; acc < 2; acc++) begin
          do_reset();
          if (ph >= 1) go_compute();
          if (ph == 2) repeat (LAT) tick();
          key_deriv = kd[0];
          if (acc == 0) din_wr = 1; else dout_rd = 1;
          tick();
          din_wr = 0; dout_rd = 0; key_deriv = 0;
          ew = (acc == 0 && ph != 0 && kd == 0) ? 32'h4 : 32'h0;
          er = (acc == 1 && ph != 2 && kd == 0) ? 32'h2 : 32'h0;
          if (kd == 1)      check("R7 errors suppressed", status & 32'h6, 32'h0);
          else if (acc == 0) check("R4 write error", status & 32'h6, ew | er);
          else              check("R5 read error", status & 32'h6, ew | er);
          check("R2 upper bits zero", status >> 3, 32'h0);
          err_clr = 1; tick(); err_clr = 0;
          check("R6 errors cleared", status & 32'h6, 32'h0);
        end
      end
    end

    // R8 stray writes do not stretch computation
    do_reset();
    go_compute();
    din_wr = 1;
    repeat (LAT) tick();
    din_wr = 0;
    check("R8 compute length with writes", {30'b0, phase}, 32'd2);
    check("R4 write error in compute", status & 32'h4, 32'h4);
    for (int i = 0; i < WORDS; i++) rd_word();
    rd_word();
    check("R8 stray read stays loading", {30'b0, phase}, 32'd0);
    go_compute();
    check("R8 stray read not counted", {30'b0, phase}, 32'd1);

    // R11 set beats clear
    do_reset();
    go_compute();
    din_wr = 1; err_clr = 1; tick(); din_wr = 0; err_clr = 0;
    check("R11 write error wins", status & 32'h4, 32'h4);
    repeat (LAT - 1) tick();
    ccf_clr = 1; tick(); ccf_clr = 0;
    check("R11 ccf wins", status & 32'h1, 32'h1);

    // R10 DMA output enabled
    do_reset();
    dma_out_en = 1;
    go_compute();
    repeat (LAT + 2) tick();
    check("R10 no ccf under DMA", status & 32'h1, 32'h0);
    for (int i = 0; i < WORDS; i++) rd_word();
    dma_out_en = 0;
    go_compute();
    repeat (LAT + 1) tick();
    check("R9 ccf without DMA", status & 32'h1, 32'h1);
    for (int i = 0; i < WORDS; i++) rd_word();
    dma_out_en = 1;
    go_compute();
    repeat (LAT + 2) tick();
    check("R10 ccf held under DMA", status & 32'h1, 32'h1);
    ccf_clr = 1; tick(); ccf_clr = 0;
    check("R10 clear under DMA", status & 32'h1, 32'h0);

    // R12 enable sweep against each flag source
    for (int ie = 0; ie < 4; ie++) begin
      for (int src = 0; src < 3; src++) begin
        do_reset();
        err_ie = ie[0];
        ccf_ie = ie[1];
        if (src == 0) begin
          go_compute();
          repeat (LAT + 1) tick();
          exp_irq = ie[1];
        end else if (src == 1) begin
          go_compute();
          wr_word();
          exp_irq = ie[0];
        end else begin
          rd_word();
          exp_irq = ie[0];
        end
        check("R12 irq registered", {31'b0, irq}, 32'h0);
        tick();
        check("R12 irq combine", {31'b0, irq}, {31'b0, exp_irq});
        err_clr = 1; ccf_clr = 1; tick(); err_clr = 0; ccf_clr = 0;
        tick();
        check("R12 irq drops", {31'b0, irq}, 32'h0);
      end
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule